// File: doc/BRIEF.md
# Software-Clocked PHY Configuration Register Port

This block accepts a 32-bit command word from a single host register write and uses it to drive a small configuration register file for a multi-port PHY. The register file has no real clock or reset of its own. Both are bits inside the command word that software toggles, so the block holds the last word it received and watches one of its bits for a rising edge. A write into the register file commits on that edge.

Software performs one register update with three host writes of the same word: first with the test-clock bit low, then with it high, then low again. The held word also selects which register appears on the combinational read-back output. One bit of one register on the first port is brought out as the PHY clock-enable.

Top module: `tp_regport`

## Requirements
- R1: In the command word, bits 7:0 are the data byte, bits 15:8 the register address and bits 18:16 the port number. A committed write stores the data byte into the register with that port and address.
- R2: A write commits only when bit 22 (test clock) rises between held words while bit 21 (write enable) is 1. A rising edge with bit 21 at 0 changes no register.
- R3: Re-sending a word with bit 22 still high commits nothing, even if its data differs. Only a fresh low-to-high transition commits.
- R4: Bit 23 is an active-low soft reset. While it is 0 in the held word, every register reads 0 and no write commits.
- R5: Only ports 0 and 1 exist. A commit that names port 2 to 7 changes no register, and a read of such a port returns 0.
- R6: `phy_clk_en_o` equals bit 2 of register 0x06 of port 0. Registers on port 1 have no effect on it.
- R7: `rd_data_o` returns the register selected by the port and address fields of the held word. It follows the register contents and the held word without extra delay.
- R8: Asserting `rst_ni` clears the held word and every register at once, so `rd_data_o` and `phy_clk_en_o` read 0.
- R9: The held word changes only on a cycle with `wr_en_i` high. `wr_data_i` is ignored at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe for the command word |
| wr_data_i | input | 32 | Command word |
| rd_data_o | output | 8 | Register selected by the held word |
| phy_clk_en_o | output | 1 | PHY clock enable, from port 0 register 0x06 bit 2 |

## Verification
A command word is captured at the clock edge where the strobe is seen. Any commit or soft clear it causes lands in the register file at the following edge. So read-back and the clock-enable are due two edges after the strobe. Each host write is one strobe cycle followed by one idle cycle, and outputs are sampled on the falling edge after that idle cycle. The table applies one host write per row, so a row shows the value after that write. The directed tests for the ignored strobe and the hard reset sample in the same way.

// File: rtl/phy_tp_pkg.sv
package phy_tp_pkg;
  localparam int WORD_W    = 32;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int PORT_W    = 3;
  localparam int DATA_LSB  = 0;
  localparam int ADDR_LSB  = 8;
  localparam int PORT_LSB  = 16;
  localparam int WREN_BIT  = 21;
  localparam int TCLK_BIT  = 22;
  localparam int SRSTN_BIT = 23;

  typedef struct packed {
    logic              srst_n;
    logic              tclk;
    logic              wren;
    logic [PORT_W-1:0] port;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } tp_cmd_t;

  function automatic tp_cmd_t tp_decode(input logic [WORD_W-1:0] w);
    tp_cmd_t c;
    c.srst_n = w[SRSTN_BIT];
    c.tclk   = w[TCLK_BIT];
    c.wren   = w[WREN_BIT];
    c.port   = w[PORT_LSB +: PORT_W];
    c.addr   = w[ADDR_LSB +: ADDR_W];
    c.data   = w[DATA_LSB +: DATA_W];
    return c;
  endfunction
endpackage

// File: rtl/tp_cmd_hold.sv
module tp_cmd_hold
  import phy_tp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output tp_cmd_t           cmd_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (wr_en_i) word_q <= wr_data_i;
  end

  assign cmd_o = tp_decode(word_q);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(word_q));
endmodule

// File: rtl/tp_edge_detect.sv
module tp_edge_detect
  import phy_tp_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  tp_cmd_t cmd_i,
  output logic    commit_o
);
  logic tclk_prev_q;
  logic port_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tclk_prev_q <= 1'b0;
    else         tclk_prev_q <= cmd_i.tclk;
  end

  assign port_ok  = 32'(cmd_i.port) < NUM_PORTS;
  assign commit_o = cmd_i.tclk && !tclk_prev_q && cmd_i.wren &&
                    cmd_i.srst_n && port_ok;

  // one rising edge, one commit
  p_single_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
endmodule

// File: rtl/tp_port_bank.sv
module tp_port_bank #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int TAP_ADDR = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] tap_o
);
  localparam int NUM_REGS = 2 ** ADDR_W;

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[raddr_i];
  assign tap_o   = regs_q[TAP_ADDR];

  p_write_lands_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clear_i && raddr_i == waddr_i) |=>
      (!$stable(raddr_i) || rdata_o == $past(wdata_i)));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (rdata_o == '0 && tap_o == '0));
endmodule

// File: rtl/tp_regport.sv
module tp_regport
  import phy_tp_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int CLK_EN_PORT = 0,
  parameter int CLK_EN_ADDR = 6,
  parameter int CLK_EN_BIT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              phy_clk_en_o
);
  tp_cmd_t           cmd;
  logic              commit;
  logic [NUM_PORTS-1:0] bank_we;
  logic [DATA_W-1:0] bank_rd  [NUM_PORTS];
  logic [DATA_W-1:0] bank_tap [NUM_PORTS];

  tp_cmd_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cmd_o     (cmd)
  );

  tp_edge_detect #(.NUM_PORTS(NUM_PORTS)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .commit_o (commit)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bank
    assign bank_we[p] = commit && (32'(cmd.port) == p);

    tp_port_bank #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .TAP_ADDR (CLK_EN_ADDR)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (!cmd.srst_n),
      .we_i    (bank_we[p]),
      .waddr_i (cmd.addr),
      .wdata_i (cmd.data),
      .raddr_i (cmd.addr),
      .rdata_o (bank_rd[p]),
      .tap_o   (bank_tap[p])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (32'(cmd.port) == p) rd_data_o = bank_rd[p];
  end

  assign phy_clk_en_o = bank_tap[CLK_EN_PORT][CLK_EN_BIT];

  p_one_bank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_we) && (commit || bank_we == '0));

  p_clk_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit && cmd.srst_n) |=> $stable(phy_clk_en_o));
endmodule

// File: tb/tp_regport_tb_top.sv
module tp_regport_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_data;
  logic        clk_en;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tp_regport dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_en_i      (wr_en),
    .wr_data_i    (wr_data),
    .rd_data_o    (rd_data),
    .phy_clk_en_o (clk_en)
  );

  // word: [23]=srst_n [22]=tclk [21]=wren [18:16]=port [15:8]=addr [7:0]=data
  localparam int NV = 29;
  localparam logic [31:0] V_WORD [NV] = '{
    32'h00A010A5, 32'h00E010A5, 32'h00A010A5,             // R1 port0
    32'h00A1103C, 32'h00E1103C, 32'h00A1103C,             // R1 port1
    32'h00801000,                                         // R7
    32'h00C01011, 32'h00A01022, 32'h00E01022,             // R2
    32'h00E01077, 32'h00A01077,                           // R3
    32'h00A00604, 32'h00E00604, 32'h00A00604,             // R6
    32'h00A106FB, 32'h00E106FB, 32'h00A006FB,
    32'h00E006FB, 32'h00A006FB,
    32'h00A21099, 32'h00E21099, 32'h00A21099,             // R5
    32'h00801000, 32'h00811000,
    32'h00001000, 32'h00601055, 32'h00801000, 32'h00811000 // R4
  };
  // {clk_en, rd_data}
  localparam logic [8:0] V_EXP [NV] = '{
    9'h000, 9'h0A5, 9'h0A5,
    9'h000, 9'h03C, 9'h03C,
    9'h0A5,
    9'h0A5, 9'h0A5, 9'h022,
    9'h022, 9'h022,
    9'h000, 9'h104, 9'h104,
    9'h100, 9'h1FB, 9'h104,
    9'h0FB, 9'h0FB,
    9'h000, 9'h000, 9'h000,
    9'h022, 9'h03C,
    9'h000, 9'h000, 9'h000, 9'h000
  };
  localparam string V_REQ [NV] = '{
    "R1", "R1", "R1", "R1", "R1", "R1", "R7",
    "R2", "R2", "R2", "R3", "R3",
    "R6", "R6", "R6", "R6", "R6", "R6", "R6", "R6",
    "R5", "R5", "R5", "R5", "R5",
    "R4", "R4", "R4", "R4"
  };

  task automatic host_write(input logic [31:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got clk_en=%0b rd=%02h, expected clk_en=%0b rd=%02h",
               req, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: got hung run, expected completion");
          $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    check("R8", {clk_en, rd_data}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      host_write(V_WORD[i]);
      check(V_REQ[i], {clk_en, rd_data}, V_EXP[i]);
    end

    // R9: strobe low, word on the data bus must not land
    host_write(32'h00A0205A);
    host_write(32'h00E0205A);
    host_write(32'h00A0205A);
    check("R1", {clk_en, rd_data}, 9'h05A);
    @(negedge clk); wr_data = 32'h00E020FF;
    repeat (3) @(negedge clk);
    wr_data = 32'h00A020EE;
    repeat (3) @(negedge clk);
    check("R9", {clk_en, rd_data}, 9'h05A);

    // R8: hard reset clears registers and clock enable
    host_write(32'h00A00604);
    host_write(32'h00E00604);
    host_write(32'h00A0205A);
    check("R6", {clk_en, rd_data}, 9'h15A);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R8", {clk_en, rd_data}, 9'h000);
    @(negedge clk); rst_n = 1'b1;
    host_write(32'h00802000);
    check("R8", {clk_en, rd_data}, 9'h000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule